// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Controller

This block is the digital front end of a serial byte memory. It behaves as a slave on a four-wire SPI bus in clock modes 0 and 3 and holds a byte-wide array of 2^ADDR_W bytes (2048 by default). The bus pins are oversampled in the system clock domain, and edges of the serial clock are detected there. No logic is clocked from the serial clock.

A host sends an 8-bit instruction, MSB first, followed by an address or data as the instruction needs. Reads stream bytes with automatic address increment. Writes collect up to one page (2^PAGE_W bytes, 32 by default) in a page buffer. When chip select rises at a legal point, the page is committed during a timed busy period of WRITE_TICKS clocks. A status byte can be read at any time. An external protection unit is asked through a small query interface whether the pending commit is allowed. The protection unit receives the stored protection level and lock bit.

Top module: `eep_spi_slave`

## Requirements
- R1: Bits are taken from spi_mosi on rising serial-clock edges and driven on spi_miso after falling edges, MSB first, in both clock modes 0 and 3. spi_miso_oe is 1 only while chip select is low, and it is 0 after reset.
- R2: Instruction codes are 0x06 enable writes, 0x04 disable writes and clear the flag, 0x00 set the flag, 0x05 read status, 0x01 write status, 0x03 read array and 0x02 write array. Any other code is ignored until chip select rises.
- R3: Enable-writes sets the write-enable bit only if chip select rises directly after its eighth bit. If any further clock follows, the instruction has no effect. Disable-writes clears both the write-enable bit and the flag. Set-flag sets the flag.
- R4: Read array takes a 16-bit address, of which the low ADDR_W bits are used. It then returns consecutive bytes, incrementing the address after each byte and wrapping from the top address to 0, until chip select rises.
- R5: Write array takes a 16-bit address followed by data bytes. The byte position advances inside the addressed 32-byte page and wraps to the start of that page. A later byte for the same position replaces the earlier one.
- R6: A write-array or write-status sequence is committed only if chip select rises directly after the last bit of a whole data byte. A rise at any other point leaves array and status unchanged.
- R7: A commit also requires the write-enable bit to be set and chk_grant to be 1 at the moment chip select rises. chk_addr presents the page base of the pending array write, and chk_is_status is 1 for a pending status write.
- R8: A commit keeps the busy bit set for WRITE_TICKS clocks. At the end of the busy period the write-enable bit is cleared.
- R9: While busy, every instruction other than read status is ignored. Read status works during busy.
- R10: Status byte layout: bit 0 busy, bit 1 write enable, bits 3:2 protection level, bit 4 flag, bit 7 lock, bits 6:5 zero. A status write loads data bits 3:2 and bit 7 into protection level and lock when its busy period ends. Data bits 1:0 have no effect.
- R11: After reset, no instruction is accepted until chip select has made a high-to-low transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block |
| spi_miso_oe | output | 1 | Output enable for spi_miso |
| chk_addr | output | ADDR_W | Page base address of the pending array write |
| chk_is_status | output | 1 | Pending write targets the status byte |
| chk_grant | input | 1 | Protection unit allows the pending write |
| prot_level | output | 2 | Stored protection level |
| lock_en | output | 1 | Stored lock bit |

## Verification
A serial-clock edge reaches the control logic three system clocks after it happens: two synchronizer stages plus the registered edge detect. spi_miso therefore changes about four clocks after a falling edge. The bench holds each serial-clock half period for six clocks and samples spi_miso just before the next rising edge. A commit starts about four clocks after chip select rises and lasts WRITE_TICKS clocks. The bench reads status within the first few hundred clocks of that window to see busy, then polls until busy clears before it compares array contents or the stored protection bits.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [7:0] {
    OP_SETFLAG = 8'h00,
    OP_WRSTAT  = 8'h01,
    OP_WRITE   = 8'h02,
    OP_READ    = 8'h03,
    OP_WRDIS   = 8'h04,
    OP_RDSTAT  = 8'h05,
    OP_WREN    = 8'h06
  } opcode_e;
endpackage

// File: rtl/eep_pin_sync.sv
module eep_pin_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RESET_VAL;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/eep_commit_timer.sv
module eep_commit_timer #(
  parameter int TICKS = 500_000,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic             idx_valid,
  output logic             done
);
  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);
  localparam logic [CW-1:0] SPAN = CW'(1 << IDX_W);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == LAST) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end
  end

  assign done      = busy && (cnt == LAST);
  assign idx       = cnt[IDX_W-1:0];
  assign idx_valid = busy && (cnt < SPAN);

  AST_TICKS_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt <= LAST)); // R8
  AST_START_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (cnt == '0)); // R8
endmodule

// File: rtl/eep_spi_slave.sv
module eep_spi_slave
  import eep_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int PAGE_W      = 5,
  parameter int WRITE_TICKS = 500_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_csn,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic [ADDR_W-1:0] chk_addr,
  output logic              chk_is_status,
  input  logic              chk_grant,
  output logic [1:0]        prot_level,
  output logic              lock_en
);
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int PG_W   = ADDR_W - PAGE_W;
  localparam int HI_W   = ADDR_W - 8;

  // pin synchronizers: {csn, sck, mosi}; reset value keeps chip select "low"
  logic [2:0] pins_q;
  logic       csn_q, sck_q, mosi_q, csn_p, sck_p;

  eep_pin_sync #(.W(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b000)) u_sync (
    .clk(clk), .rst(rst), .din({spi_csn, spi_sck, spi_mosi}), .q(pins_q)
  );
  assign {csn_q, sck_q, mosi_q} = pins_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      csn_p <= 1'b0;
      sck_p <= 1'b0;
    end else begin
      csn_p <= csn_q;
      sck_p <= sck_q;
    end
  end

  logic csn_fall, csn_rise, sck_rise, sck_fall;
  assign csn_fall = csn_p & ~csn_q;
  assign csn_rise = ~csn_p & csn_q;
  assign sck_rise = sck_q & ~sck_p;
  assign sck_fall = ~sck_q & sck_p;

  // protocol state
  logic              armed, skip;
  logic [7:0]        op, sh;
  logic [2:0]        bitcnt, nb;
  logic [HI_W-1:0]   addr_hi;
  logic [ADDR_W-1:0] addr;
  logic [PAGE_W-1:0] off;
  logic              wel, flag, lock, pend_lock, cm_stat;
  logic [1:0]        lvl, pend_lvl;
  logic [PG_W-1:0]   cm_page;
  logic [PAGE_N-1:0] pmask;
  logic [7:0]        pbuf [PAGE_N];

  logic [7:0] sh_next, status, rd_q;
  logic       active, byte_done, busy, tmr_start, tmr_done, idx_valid;
  logic       wren_ok, commit_ok, arr_we;
  logic [PAGE_W-1:0] idx;

  assign sh_next   = {sh[6:0], mosi_q};
  assign active    = armed & ~csn_q;
  assign byte_done = sck_rise && (bitcnt == 3'd7);
  assign status    = {lock, 2'b00, flag, lvl, wel, busy};

  assign wren_ok   = armed && !skip && !busy && bitcnt == 3'd0 && nb == 3'd1 && op == OP_WREN;
  assign commit_ok = armed && !skip && !busy && wel && chk_grant && bitcnt == 3'd0 &&
                     ((op == OP_WRITE && nb >= 3'd4) || (op == OP_WRSTAT && nb >= 3'd2));
  assign tmr_start = csn_rise && commit_ok;

  assign chk_addr      = {addr[ADDR_W-1:PAGE_W], {PAGE_W{1'b0}}};
  assign chk_is_status = (op == OP_WRSTAT);
  assign prot_level    = lvl;
  assign lock_en       = lock;

  eep_commit_timer #(.TICKS(WRITE_TICKS), .IDX_W(PAGE_W)) u_timer (
    .clk(clk), .rst(rst), .start(tmr_start), .busy(busy),
    .idx(idx), .idx_valid(idx_valid), .done(tmr_done)
  );

  assign arr_we = busy && idx_valid && !cm_stat && pmask[idx];

  eep_array #(.AW(ADDR_W), .DW(8)) u_array (
    .clk(clk), .we(arr_we), .waddr({cm_page, idx}), .wdata(pbuf[idx]),
    .raddr(addr), .rdata(rd_q)
  );

  // page buffer storage (no reset, plain write port)
  always_ff @(posedge clk) begin
    if (active && !csn_fall && byte_done && nb >= 3'd3 && !skip && op == OP_WRITE)
      pbuf[off] <= sh_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;  skip <= 1'b1;  op <= OP_RDSTAT;  sh <= '0;
      bitcnt <= '0;   nb <= '0;      addr_hi <= '0;    addr <= '0;   off <= '0;
      wel <= 1'b0;    flag <= 1'b0;  lvl <= '0;        lock <= 1'b0;
      pend_lvl <= '0; pend_lock <= 1'b0; pmask <= '0;  cm_stat <= 1'b0; cm_page <= '0;
      spi_miso <= 1'b0; spi_miso_oe <= 1'b0;
    end else begin
      spi_miso_oe <= active;
      if (tmr_done) begin
        wel <= 1'b0;
        if (cm_stat) begin
          lvl  <= pend_lvl;
          lock <= pend_lock;
        end
      end
      if (tmr_start) begin
        cm_stat <= (op == OP_WRSTAT);
        cm_page <= addr[ADDR_W-1:PAGE_W];
      end
      if (csn_fall) begin
        armed <= 1'b1;  bitcnt <= '0;  nb <= '0;  skip <= 1'b0;
      end else if (csn_rise) begin
        if (wren_ok) wel <= 1'b1;
      end else if (active && sck_rise) begin
        sh     <= sh_next;
        bitcnt <= bitcnt + 1'b1;
        if (bitcnt == 3'd7) begin
          if (nb != 3'd7) nb <= nb + 1'b1;
          if (nb == 3'd0) begin
            op <= sh_next;
            if (busy && sh_next != OP_RDSTAT) skip <= 1'b1;
            else begin
              case (sh_next)
                OP_WRDIS:   begin wel <= 1'b0; flag <= 1'b0; end
                OP_SETFLAG: flag <= 1'b1;
                OP_WRITE:   pmask <= '0;
                OP_WREN, OP_RDSTAT, OP_READ, OP_WRSTAT: ;
                default:    skip <= 1'b1;
              endcase
            end
          end else if (!skip) begin
            if (op == OP_WRSTAT) begin
              pend_lvl  <= sh_next[3:2];
              pend_lock <= sh_next[7];
            end
            if (op == OP_READ || op == OP_WRITE) begin
              if (nb == 3'd1) addr_hi <= sh_next[HI_W-1:0];
              else if (nb == 3'd2) begin
                addr <= {addr_hi, sh_next};
                off  <= sh_next[PAGE_W-1:0];
              end else if (op == OP_READ) addr <= addr + 1'b1;
              else begin
                pmask[off] <= 1'b1;
                off        <= off + 1'b1;
              end
            end
          end
        end
      end else if (active && sck_fall && !skip) begin
        if (op == OP_READ && nb >= 3'd3)        spi_miso <= rd_q[~bitcnt];
        else if (op == OP_RDSTAT && nb >= 3'd1) spi_miso <= status[~bitcnt];
      end
    end
  end

  AST_START_NEEDS_WEL: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wel)); // R7
  AST_START_ON_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(bitcnt) == 3'd0)); // R6
  AST_WEL_DROPS_AT_END: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !wel); // R8
  AST_FLAG_FROZEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(flag)); // R9
  AST_UNARMED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !armed |-> (!spi_miso_oe && !wel)); // R11
endmodule

// File: tb/eep_spi_slave_test.sv
module eep_spi_slave_test;
  localparam int AW = 11;
  localparam int TICKS = 1500;
  localparam int H = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic csn = 1'b0, sck = 1'b0, mosi = 1'b0, allow = 1'b1;
  logic miso, miso_oe, is_stat, lock_en;
  logic [AW-1:0] chk_addr;
  logic [1:0] lvl;

  always #5 clk = ~clk;

  eep_spi_slave #(.ADDR_W(AW), .PAGE_W(5), .WRITE_TICKS(TICKS), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .spi_csn(csn), .spi_sck(sck), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .chk_addr(chk_addr),
    .chk_is_status(is_stat), .chk_grant(allow), .prot_level(lvl), .lock_en(lock_en)
  );

  int nchk = 0, nerr = 0;
  bit finished = 0;
  logic [7:0] tx [0:40];
  logic [7:0] rx [0:40];
  logic [7:0] wd [0:40];
  logic [7:0] m  [0:2047];
  bit         mv [0:2047];
  logic       oe_seen;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] stat_byte(input bit lk, input logic [1:0] lv,
                                           input bit fl, input bit we, input bit bz);
    return {lk, 2'b00, fl, lv, we, bz};
  endfunction

  task automatic xfer(input int nbits, input bit mode3);
    sck = mode3;
    tick(H);
    csn = 1'b0;
    tick(H);
    for (int i = 0; i < nbits; i++) begin
      sck = 1'b0;
      mosi = tx[i/8][7 - (i % 8)];
      tick(H);
      rx[i/8][7 - (i % 8)] = miso;
      if (i == 0) oe_seen = miso_oe;
      sck = 1'b1;
      tick(H);
    end
    if (!mode3) sck = 1'b0;
    tick(H);
    csn = 1'b1;
    tick(2 * H);
  endtask

  task automatic op_only(input logic [7:0] op, input int extra);
    tx[0] = op; tx[1] = 8'h00;
    xfer(8 + extra, 1'b0);
  endtask

  task automatic rd_status(output logic [7:0] s);
    tx[0] = 8'h05; tx[1] = 8'h00;
    xfer(16, 1'b0);
    s = rx[1];
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    rd_status(s);
    while (s[0]) rd_status(s);
  endtask

  task automatic write_arr(input int a, input int n, input int extra);
    tx[0] = 8'h02; tx[1] = 8'(a >> 8); tx[2] = 8'(a);
    for (int i = 0; i < n; i++) tx[3+i] = wd[i];
    xfer((3 + n) * 8 + extra, 1'b0);
  endtask

  task automatic model_write(input int a, input int n);
    for (int i = 0; i < n; i++) begin
      int p;
      p = (a & 11'h7E0) | ((a + i) & 31);
      m[p] = wd[i];
      mv[p] = 1'b1;
    end
  endtask

  task automatic read_chk(input string req, input int a, input int n, input bit mode3);
    tx[0] = 8'h03; tx[1] = 8'(a >> 8); tx[2] = 8'(a);
    for (int i = 0; i < n; i++) tx[3+i] = 8'h00;
    xfer((3 + n) * 8, mode3);
    for (int i = 0; i < n; i++) begin
      int p;
      p = (a + i) % 2048;
      if (mv[p]) check(req, {24'h0, rx[3+i]}, {24'h0, m[p]});
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [7:0] s;
    for (int i = 0; i < 2048; i++) begin m[i] = 8'h00; mv[i] = 1'b0; end
    tick(5);
    rst = 1'b0;
    tick(4);
    check("R1 reset oe", {31'h0, miso_oe}, 32'h0);
    // chip select held low since reset: this enable-writes must be ignored
    op_only(8'h06, 0);
    check("R11 no fall yet oe", {31'h0, oe_seen}, 32'h0);
    rd_status(s);
    check("R11 status", {24'h0, s}, {24'h0, stat_byte(0, 2'd0, 0, 0, 0)});
    check("R1 oe while selected", {31'h0, oe_seen}, 32'h1);

    op_only(8'h06, 0);
    rd_status(s);
    check("R3 wren sets", {24'h0, s}, {24'h0, stat_byte(0, 2'd0, 0, 1, 0)});
    op_only(8'h00, 0);
    rd_status(s);
    check("R3 set flag", {24'h0, s}, {24'h0, stat_byte(0, 2'd0, 1, 1, 0)});
    op_only(8'h04, 0);
    rd_status(s);
    check("R3 disable clears", {24'h0, s}, {24'h0, stat_byte(0, 2'd0, 0, 0, 0)});
    op_only(8'h06, 8);
    rd_status(s);
    check("R3 wren extra clocks", {24'h0, s}, {24'h0, stat_byte(0, 2'd0, 0, 0, 0)});
    op_only(8'h07, 0);
    rd_status(s);
    check("R2 unknown code", {24'h0, s}, {24'h0, stat_byte(0, 2'd0, 0, 0, 0)});

    // basic write with busy window
    op_only(8'h06, 0);
    wd[0] = 8'hA5; wd[1] = 8'h3C; wd[2] = 8'h96;
    write_arr(11'h123, 3, 0);
    model_write(11'h123, 3);
    rd_status(s);
    check("R8 busy during commit", {24'h0, s}, {24'h0, stat_byte(0, 2'd0, 0, 1, 1)});
    wait_idle();
    rd_status(s);
    check("R8 wel cleared after", {24'h0, s}, {24'h0, stat_byte(0, 2'd0, 0, 0, 0)});
    read_chk("R4 read back", 11'h123, 3, 1'b0);

    // page wrap
    op_only(8'h06, 0);
    wd[0] = 8'h11; wd[1] = 8'h22; wd[2] = 8'h33; wd[3] = 8'h44;
    write_arr(11'h05E, 4, 0);
    model_write(11'h05E, 4);
    wait_idle();
    read_chk("R5 wrap tail", 11'h05E, 2, 1'b0);
    read_chk("R5 wrap head", 11'h040, 2, 1'b0);

    // aborted writes
    op_only(8'h06, 0);
    wd[0] = 8'hFF; wd[1] = 8'hEE;
    write_arr(11'h123, 2, 3);
    rd_status(s);
    check("R6 mid-byte abort", {24'h0, s}, {24'h0, stat_byte(0, 2'd0, 0, 1, 0)});
    write_arr(11'h123, 0, 0);
    rd_status(s);
    check("R6 address-only abort", {24'h0, s}, {24'h0, stat_byte(0, 2'd0, 0, 1, 0)});
    read_chk("R6 data unchanged", 11'h123, 3, 1'b0);

    // protection denies
    allow = 1'b0;
    write_arr(11'h124, 1, 0);
    check("R7 query page", {21'h0, chk_addr}, 32'h120);
    check("R7 query kind", {31'h0, is_stat}, 32'h0);
    rd_status(s);
    check("R7 denied no busy", {24'h0, s}, {24'h0, stat_byte(0, 2'd0, 0, 1, 0)});
    allow = 1'b1;
    op_only(8'h04, 0);
    write_arr(11'h124, 1, 0);
    rd_status(s);
    check("R7 no wel no busy", {24'h0, s}, {24'h0, stat_byte(0, 2'd0, 0, 0, 0)});
    read_chk("R7 data unchanged", 11'h123, 3, 1'b0);

    // read wrap over the top address
    op_only(8'h06, 0);
    wd[0] = 8'h5A; wd[1] = 8'hC3;
    write_arr(11'h7FE, 2, 0); model_write(11'h7FE, 2); wait_idle();
    op_only(8'h06, 0);
    wd[0] = 8'h81; wd[1] = 8'h7E;
    write_arr(11'h000, 2, 0); model_write(11'h000, 2); wait_idle();
    read_chk("R4 array wrap", 11'h7FE, 4, 1'b0);
    read_chk("R1 mode 3 read", 11'h7FE, 4, 1'b1);

    // status write
    op_only(8'h06, 0);
    tx[0] = 8'h01; tx[1] = 8'h8F;
    xfer(16, 1'b0);
    check("R7 query status kind", {31'h0, is_stat}, 32'h1);
    rd_status(s);
    check("R10 busy on status write", {24'h0, s}, {24'h0, stat_byte(0, 2'd0, 0, 1, 1)});
    wait_idle();
    rd_status(s);
    check("R10 status stored", {24'h0, s}, {24'h0, stat_byte(1, 2'd3, 0, 0, 0)});
    check("R10 level port", {30'h0, lvl}, 32'h3);
    check("R10 lock port", {31'h0, lock_en}, 32'h1);

    // instructions during busy
    op_only(8'h06, 0);
    wd[0] = 8'hAA;
    write_arr(11'h300, 1, 0); model_write(11'h300, 1);
    op_only(8'h00, 0);
    op_only(8'h06, 0);
    wait_idle();
    rd_status(s);
    check("R9 ignored while busy", {24'h0, s}, {24'h0, stat_byte(1, 2'd3, 0, 0, 0)});
    read_chk("R9 commit intact", 11'h300, 1, 1'b0);

    // constrained random page writes
    void'($urandom(32'd1234));
    for (int it = 0; it < 8; it++) begin
      int a, n;
      a = $urandom % 2048;
      n = 1 + ($urandom % 34);
      for (int i = 0; i < n; i++) wd[i] = 8'($urandom);
      op_only(8'h06, 0);
      write_arr(a, n, 0);
      model_write(a, n);
      wait_idle();
      read_chk("R5 random page", a & 11'h7E0, 32, 1'($urandom));
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule